// File: doc/BRIEF.md
# Double-Rate Paged Bus Target Bridge

This block sits on the target side of a narrow pipelined bus whose address, data and byte-select pins each carry two values per clock period. It captures the low byte of every field on the rising clock edge and the high byte on the falling edge. The two bytes form a 16-bit address word, a 16-bit data word and a 2-bit byte-enable. Select is sent serially, with the high-lane enable first.

Every bus cycle (CYC high) opens with a page-select transaction. Its address word is the low half and its data word is the high half of a 32-bit page number. Each later transaction names a 16-bit word offset inside that page. The bridge turns each one into a single-rate request on a local memory port, whose word address is the page number followed by the offset.

Answers return on one double-rate response pin as a 2-bit code. On reads the bridge also drives the shared data pins for the length of that answer.

Top module: `ddrpg_target`

## Requirements
- R1: Each transaction's low bytes (address, data) are taken at the rising edge and its high bytes at the falling edge of the same clock period. The first select bit is byte-enable bit 1 and the second is bit 0.
- R2: The first transaction of a bus cycle is the page select, with page = {data word, address word}. A valid page is answered with ACK. Later requests use memory word address {page, offset}.
- R3: A page select answers ERR when the page number is not below PAGE_COUNT, and RTY when the memory port is not ready. In both cases every further transaction of that bus cycle gets no answer and no memory request.
- R4: The answer to a transaction captured in period k is given in period k+1. Response codes are 00 none, 01 ACK, 10 ERR and 11 RTY. Bit 1 is on the pin while the clock is high and bit 0 while it is low.
- R5: In a read cycle (TGC=0), the ACK of the page select drives a zero word. The ACK of a data read drives the memory word, with the low byte while the clock is high and the high byte while it is low.
- R6: In a write cycle (TGC=1), the bridge never enables its data output. Each write goes to memory with the captured data word and byte-enable.
- R7: While a data transaction waits for a not-ready memory port, STALL is high and no answer is given. Once the port is ready, the held transaction is served once and answered with ACK.
- R8: A data transaction whose offset is not below WORD_LIMIT is answered with ERR and makes no memory request. The page stays open for later transactions.
- R9: A strobe while CYC is low is ignored. After CYC falls, the page is forgotten, and the first transaction of the next bus cycle is a new page select.
- R10: The data output enable is high only during the answer period of a read-cycle transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; both edges used for capture |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_i | input | 1 | Bus cycle active |
| stb_i | input | 1 | Transaction strobe, rising-edge sampled |
| tgc_i | input | 1 | Cycle kind: 1 write, 0 read |
| stall_o | output | 1 | Target cannot take the presented transaction |
| adr_i | input | LANE_W | Address lane, double rate |
| dat_i | input | LANE_W | Data lane from initiator, double rate |
| dat_o | output | LANE_W | Data lane to initiator, double rate |
| dat_oe_o | output | 1 | Drive enable for the shared data pins |
| sel_i | input | 1 | Serial byte-enable, double rate |
| rsp_o | output | 1 | Serial response code, double rate |
| mem_req_o | output | 1 | Memory request, taken when mem_ready_i is high |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 3*2*LANE_W | Word address {page, offset} |
| mem_wdata_o | output | 2*LANE_W | Write data word |
| mem_be_o | output | 2 | Byte enables for the write |
| mem_ready_i | input | 1 | Memory port can take a request |
| mem_rdata_i | input | 2*LANE_W | Read word, valid in the period after a read is taken |

## Verification
A stalled read and the memory port becoming ready can meet in one period. If the release lands at the wrong point, the held transaction could be answered twice, or answered while STALL is still showing. The bench holds the port not ready over two stalled periods and raises readiness during the high phase of the third. It then requires exactly two stalls, silence on the response and data pins until the release, and a single ACK carrying the stored word.

// File: rtl/ddrpg_pkg.sv
// Shared encodings of the double-rate paged target bridge.
// Assumes: the response code is shifted out bit 1 first.
package ddrpg_pkg;

    typedef enum logic [1:0] {
        RSP_NONE = 2'b00,
        RSP_ACK  = 2'b01,
        RSP_ERR  = 2'b10,
        RSP_RTY  = 2'b11
    } rsp_e;

    typedef enum logic [1:0] {
        PH_SELECT = 2'b00,
        PH_OPEN   = 2'b01,
        PH_DEAD   = 2'b10
    } phase_e;

endpackage

// File: rtl/ddrpg_capture.sv
// Edge capture: rebuilds one transaction from the two half-periods.
// Low bytes and the first select bit are taken on the rising edge, and
// high bytes and the second select bit on the falling edge.
// Assumes: the initiator changes the lanes between edges.
module ddrpg_capture #(
    parameter int LANE_W = 8,
    localparam int WORD_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              tgc_i,
    input  logic [LANE_W-1:0] adr_i,
    input  logic [LANE_W-1:0] dat_i,
    input  logic              sel_i,
    output logic              tx_valid_o,
    output logic              tx_we_o,
    output logic [WORD_W-1:0] tx_adr_o,
    output logic [WORD_W-1:0] tx_dat_o,
    output logic [1:0]        tx_be_o
);

    logic [LANE_W-1:0] adr_lo_q, adr_hi_q, dat_lo_q, dat_hi_q;
    logic              be_hi_q, be_lo_q;

    // Rising edge: qualifiers, low bytes and the leading select bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid_o <= 1'b0;
            tx_we_o    <= 1'b0;
            adr_lo_q   <= '0;
            dat_lo_q   <= '0;
            be_hi_q    <= 1'b0;
        end else begin
            tx_valid_o <= cyc_i & stb_i;
            tx_we_o    <= tgc_i;
            adr_lo_q   <= adr_i;
            dat_lo_q   <= dat_i;
            be_hi_q    <= sel_i;
        end
    end

    // Falling edge: high bytes and the trailing select bit.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            adr_hi_q <= '0;
            dat_hi_q <= '0;
            be_lo_q  <= 1'b0;
        end else begin
            adr_hi_q <= adr_i;
            dat_hi_q <= dat_i;
            be_lo_q  <= sel_i;
        end
    end

    assign tx_adr_o = {adr_hi_q, adr_lo_q};
    assign tx_dat_o = {dat_hi_q, dat_lo_q};
    assign tx_be_o  = {be_hi_q, be_lo_q};

endmodule

// File: rtl/ddrpg_page_ctrl.sv
// Page tracker and request issue.
// Holds the open page and the cycle phase, sends data transactions to
// the memory port, raises stall and registers one response per
// accepted transaction.
// Assumes: the memory port takes a request on a clock edge with
// mem_ready_i high.
module ddrpg_page_ctrl
    import ddrpg_pkg::*;
#(
    parameter int LANE_W     = 8,
    parameter int PAGE_COUNT = 4,
    parameter int WORD_LIMIT = 1024,
    localparam int WORD_W  = 2 * LANE_W,
    localparam int PAGE_W  = 2 * WORD_W,
    localparam int MADDR_W = PAGE_W + WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_i,
    input  logic               tx_valid_i,
    input  logic               tx_we_i,
    input  logic [WORD_W-1:0]  tx_adr_i,
    input  logic [WORD_W-1:0]  tx_dat_i,
    input  logic [1:0]         tx_be_i,
    input  logic               mem_ready_i,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [MADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0]  mem_wdata_o,
    output logic [1:0]         mem_be_o,
    output logic               stall_o,
    output logic [1:0]         code_o,
    output logic               rd_oe_o,
    output logic               rd_mem_o
);

    localparam logic [PAGE_W:0] PAGE_LIM = (PAGE_W + 1)'(PAGE_COUNT);
    localparam logic [WORD_W:0] WORD_LIM = (WORD_W + 1)'(WORD_LIMIT);

    phase_e              phase_q, phase_d;
    rsp_e                code_q, code_d;
    logic [PAGE_W-1:0]   page_q;
    logic [PAGE_W-1:0]   selector;
    logic                is_sel, is_data, in_range, accept;

    assign selector = {tx_dat_i, tx_adr_i};
    assign is_sel   = tx_valid_i && (phase_q == PH_SELECT);
    assign is_data  = tx_valid_i && (phase_q == PH_OPEN);
    assign in_range = {1'b0, tx_adr_i} < WORD_LIM;

    assign mem_req_o   = cyc_i && is_data && in_range;
    assign mem_we_o    = tx_we_i;
    assign mem_addr_o  = {page_q, tx_adr_i};
    assign mem_wdata_o = tx_dat_i;
    assign mem_be_o    = tx_be_i;
    assign stall_o     = mem_req_o && !mem_ready_i;
    assign accept      = cyc_i && tx_valid_i && !stall_o;

    // Response for the transaction completing in this period.
    always_comb begin
        code_d = RSP_NONE;
        if (accept && is_sel) begin
            if (!mem_ready_i)                      code_d = RSP_RTY;
            else if ({1'b0, selector} >= PAGE_LIM) code_d = RSP_ERR;
            else                                   code_d = RSP_ACK;
        end else if (accept && is_data) begin
            code_d = in_range ? RSP_ACK : RSP_ERR;
        end
    end

    // Phase moves on the page-select outcome and restarts when CYC drops.
    always_comb begin
        phase_d = phase_q;
        if (!cyc_i)
            phase_d = PH_SELECT;
        else if (accept && is_sel)
            phase_d = (code_d == RSP_ACK) ? PH_OPEN : PH_DEAD;
    end

    // State and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_SELECT;
            page_q   <= '0;
            code_q   <= RSP_NONE;
            rd_oe_o  <= 1'b0;
            rd_mem_o <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            code_q   <= code_d;
            rd_oe_o  <= (code_d != RSP_NONE) && !tx_we_i;
            rd_mem_o <= is_data && (code_d == RSP_ACK) && !tx_we_i;
            if (!cyc_i)
                page_q <= '0;
            else if (is_sel && code_d == RSP_ACK)
                page_q <= selector;
        end
    end

    assign code_o = code_q;

    // A stalled transaction gets no answer in the next period.
    assert_stall_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (code_q == RSP_NONE));

    // A memory request taken by the port is acknowledged next period.
    assert_accept_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i) |=> (code_q == RSP_ACK));

    // An error answer never follows a request the memory port took.
    assert_err_no_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == RSP_ERR) |-> $past(!(mem_req_o && mem_ready_i)));

    // Nothing is answered in the period after CYC is seen low.
    assert_cyc_low_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_i |=> (code_q == RSP_NONE));

    // Write transactions never lead to a data drive.
    assert_write_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_i && tx_we_i) |=> !rd_oe_o);

endmodule

// File: rtl/ddrpg_ddr_out.sv
// Double-rate output lanes.
// Places bit 1 of the code and the low data byte in the high clock
// phase, and bit 0 and the high data byte in the low phase.
// Assumes: the inputs are stable for the whole clock period.
module ddrpg_ddr_out #(
    parameter int LANE_W = 8,
    localparam int WORD_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic [1:0]        code_i,
    input  logic              oe_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              rsp_o,
    output logic [LANE_W-1:0] dat_o,
    output logic              dat_oe_o
);

    // Phase select of the serial response bit.
    always_comb rsp_o = clk ? code_i[1] : code_i[0];

    // Phase select of the data byte, forced to zero when not driving.
    always_comb begin
        if (!oe_i)
            dat_o = '0;
        else
            dat_o = clk ? word_i[LANE_W-1:0] : word_i[WORD_W-1:LANE_W];
    end

    assign dat_oe_o = oe_i;

endmodule

// File: rtl/ddrpg_target.sv
// Target bridge from a double-rate paged bus to a single-rate memory port.
// Assumes: mem_rdata_i holds the word for the whole period after the
// port takes a read.
module ddrpg_target
    import ddrpg_pkg::*;
#(
    parameter int LANE_W     = 8,
    parameter int PAGE_COUNT = 4,
    parameter int WORD_LIMIT = 1024,
    localparam int WORD_W  = 2 * LANE_W,
    localparam int PAGE_W  = 2 * WORD_W,
    localparam int MADDR_W = PAGE_W + WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_i,
    input  logic               stb_i,
    input  logic               tgc_i,
    output logic               stall_o,
    input  logic [LANE_W-1:0]  adr_i,
    input  logic [LANE_W-1:0]  dat_i,
    output logic [LANE_W-1:0]  dat_o,
    output logic               dat_oe_o,
    input  logic               sel_i,
    output logic               rsp_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [MADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0]  mem_wdata_o,
    output logic [1:0]         mem_be_o,
    input  logic               mem_ready_i,
    input  logic [WORD_W-1:0]  mem_rdata_i
);

    logic              tx_valid, tx_we;
    logic [WORD_W-1:0] tx_adr, tx_dat;
    logic [1:0]        tx_be;
    logic [1:0]        code;
    logic              rd_oe, rd_mem;
    logic [WORD_W-1:0] out_word;

    ddrpg_capture #(.LANE_W(LANE_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .stb_i(stb_i), .tgc_i(tgc_i),
        .adr_i(adr_i), .dat_i(dat_i), .sel_i(sel_i),
        .tx_valid_o(tx_valid), .tx_we_o(tx_we), .tx_adr_o(tx_adr),
        .tx_dat_o(tx_dat), .tx_be_o(tx_be)
    );

    ddrpg_page_ctrl #(
        .LANE_W(LANE_W), .PAGE_COUNT(PAGE_COUNT), .WORD_LIMIT(WORD_LIMIT)
    ) u_page (
        .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i),
        .tx_valid_i(tx_valid), .tx_we_i(tx_we), .tx_adr_i(tx_adr),
        .tx_dat_i(tx_dat), .tx_be_i(tx_be), .mem_ready_i(mem_ready_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o), .stall_o(stall_o),
        .code_o(code), .rd_oe_o(rd_oe), .rd_mem_o(rd_mem)
    );

    // Read answers carry memory data, or zero for the page-select ACK.
    assign out_word = rd_mem ? mem_rdata_i : '0;

    ddrpg_ddr_out #(.LANE_W(LANE_W)) u_out (
        .clk(clk), .code_i(code), .oe_i(rd_oe), .word_i(out_word),
        .rsp_o(rsp_o), .dat_o(dat_o), .dat_oe_o(dat_oe_o)
    );

    // The data pins are only driven while an answer is being given.
    assert_drive_with_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dat_oe_o |-> (code != RSP_NONE));

endmodule

// File: tb/test_ddrpg_target.sv
`timescale 1ns/100ps
module test_ddrpg_target;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, tgc = 1'b0, sel = 1'b0;
    logic [7:0]  adr = '0, dat = '0;
    logic        mem_ready = 1'b1;
    logic        stall_o, dat_oe_o, rsp_o, mem_req_o, mem_we_o;
    logic [7:0]  dat_o;
    logic [47:0] mem_addr_o;
    logic [15:0] mem_wdata_o, mem_rdata;
    logic [1:0]  mem_be_o;

    int checks = 0, errors = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    ddrpg_target i_ddrpg_target (
        .clk(clk), .rst_n(rst_n), .cyc_i(cyc), .stb_i(stb), .tgc_i(tgc),
        .stall_o(stall_o), .adr_i(adr), .dat_i(dat), .dat_o(dat_o),
        .dat_oe_o(dat_oe_o), .sel_i(sel), .rsp_o(rsp_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o),
        .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
    );

    // Memory model: 16 words, read data valid the period after acceptance.
    logic [15:0] mem [16];
    logic [47:0] last_wr_addr, last_rd_addr;
    logic [15:0] last_wdata;
    logic [1:0]  last_be;
    int          wr_cnt = 0, rd_cnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= '0;
            mem_rdata <= '0;
        end else if (mem_req_o && mem_ready) begin
            if (mem_we_o) begin
                if (mem_be_o[0]) mem[mem_addr_o[3:0]][7:0]  <= mem_wdata_o[7:0];
                if (mem_be_o[1]) mem[mem_addr_o[3:0]][15:8] <= mem_wdata_o[15:8];
                last_wr_addr <= mem_addr_o;
                last_wdata   <= mem_wdata_o;
                last_be      <= mem_be_o;
                wr_cnt       <= wr_cnt + 1;
            end else begin
                mem_rdata    <= mem[mem_addr_o[3:0]];
                last_rd_addr <= mem_addr_o;
                rd_cnt       <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One transaction plus its answer period; re-presents while stalled.
    task automatic xfer(input logic we, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] be, input int rel_at,
                        output logic [1:0] code, output logic [15:0] rdata,
                        output logic oe_both, output logic oe_any,
                        output int stalls, output logic quiet);
        int n = 0;
        logic done = 1'b0;
        logic msb;
        quiet = 1'b1;
        @(negedge clk); #0.5;
        cyc = 1'b1; stb = 1'b1; tgc = we; adr = a[7:0]; dat = d[7:0]; sel = be[1];
        while (!done) begin
            @(posedge clk); #0.5;
            if (n > 0 && (rsp_o || dat_oe_o)) quiet = 1'b0;
            adr = a[15:8]; dat = d[15:8]; sel = be[0];
            if (rel_at >= 0 && n == rel_at) mem_ready = 1'b1;
            @(negedge clk); #0.5;
            if (n > 0 && (rsp_o || dat_oe_o)) quiet = 1'b0;
            if (stall_o) begin
                n++;
                adr = a[7:0]; dat = d[7:0]; sel = be[1];
            end else begin
                stb = 1'b0;
                done = 1'b1;
            end
        end
        stalls = n;
        @(posedge clk); #0.5;
        msb = rsp_o; rdata[7:0] = dat_o; oe_both = dat_oe_o; oe_any = dat_oe_o;
        @(negedge clk); #0.5;
        code = {msb, rsp_o}; rdata[15:8] = dat_o;
        oe_both = oe_both & dat_oe_o; oe_any = oe_any | dat_oe_o;
    endtask

    task automatic end_cycle();
        @(negedge clk); #0.5;
        cyc = 1'b0; stb = 1'b0;
        @(posedge clk);
    endtask

    logic [1:0]  code;
    logic [15:0] rd;
    logic        oe_b, oe_a, quiet;
    int          st, wr0;

    task automatic t_reset();
        @(negedge clk); #0.5;
        chk(!stall_o && !dat_oe_o && !rsp_o && !mem_req_o, "R10 reset idle",
            {stall_o, dat_oe_o, rsp_o, mem_req_o}, 0);
    endtask

    task automatic t_write_cycle();
        xfer(1, 16'h0002, 16'h0000, 2'b11, -1, code, rd, oe_b, oe_a, st, quiet);
        chk(code == 2'b01, "R2 page select ACK", code, 2'b01);
        chk(!oe_a, "R6 no drive on write select", oe_a, 0);
        xfer(1, 16'h0305, 16'hA1B2, 2'b10, -1, code, rd, oe_b, oe_a, st, quiet);
        chk(code == 2'b01, "R6 write ACK", code, 2'b01);
        chk(last_wr_addr == {32'h2, 16'h0305}, "R2 word address", last_wr_addr,
            {32'h2, 16'h0305});
        chk(last_wdata == 16'hA1B2, "R1 write data lanes", last_wdata, 16'hA1B2);
        chk(last_be == 2'b10, "R6 byte enables", last_be, 2'b10);
        chk(!oe_a, "R6 no drive on write", oe_a, 0);
        xfer(1, 16'h0306, 16'h5A3C, 2'b11, -1, code, rd, oe_b, oe_a, st, quiet);
        wr0 = wr_cnt;
        xfer(1, 16'h0400, 16'hFFFF, 2'b11, -1, code, rd, oe_b, oe_a, st, quiet);
        chk(code == 2'b10, "R8 offset limit ERR (R4 bit order)", code, 2'b10);
        chk(wr_cnt == wr0, "R8 no memory write", wr_cnt, wr0);
        xfer(1, 16'h0010, 16'h1234, 2'b11, -1, code, rd, oe_b, oe_a, st, quiet);
        chk(code == 2'b01, "R8 page stays open", code, 2'b01);
        end_cycle();
    endtask

    task automatic t_read_cycle();
        xfer(0, 16'h0002, 16'h0000, 2'b11, -1, code, rd, oe_b, oe_a, st, quiet);
        chk(code == 2'b01 && oe_b, "R5 read select ACK driven", {code, oe_b}, 3'b011);
        chk(rd == 16'h0000, "R5 select word zero", rd, 0);
        xfer(0, 16'h0306, 16'h0000, 2'b11, -1, code, rd, oe_b, oe_a, st, quiet);
        chk(code == 2'b01 && oe_b, "R10 read answer driven", {code, oe_b}, 3'b011);
        chk(rd == 16'h5A3C, "R5 read data lanes", rd, 16'h5A3C);
        chk(last_rd_addr == {32'h2, 16'h0306}, "R2 read address", last_rd_addr,
            {32'h2, 16'h0306});
    endtask

    task automatic t_stall();
        mem_ready = 1'b0;
        xfer(0, 16'h0010, 16'h0000, 2'b11, 2, code, rd, oe_b, oe_a, st, quiet);
        chk(st == 2, "R7 stall periods", st, 2);
        chk(quiet, "R7 silent while stalled", quiet, 1);
        chk(code == 2'b01 && rd == 16'h1234, "R7 held read served", {code, rd},
            {2'b01, 16'h1234});
        end_cycle();
    endtask

    task automatic t_new_cycle();
        wr0 = wr_cnt + rd_cnt;
        @(negedge clk); #0.5;
        stb = 1'b1; adr = 8'h06;
        @(posedge clk); #0.5; adr = 8'h03;
        @(negedge clk); #0.5; stb = 1'b0;
        @(posedge clk); #0.5; code[1] = rsp_o;
        @(negedge clk); #0.5; code[0] = rsp_o;
        chk(code == 2'b00 && wr_cnt + rd_cnt == wr0, "R9 strobe without CYC ignored",
            code, 0);
        xfer(0, 16'h0001, 16'h0000, 2'b11, -1, code, rd, oe_b, oe_a, st, quiet);
        chk(code == 2'b01 && rd == 16'h0000, "R9 first transaction is page select",
            {code, rd}, {2'b01, 16'h0});
        xfer(0, 16'h0306, 16'h0000, 2'b11, -1, code, rd, oe_b, oe_a, st, quiet);
        chk(last_rd_addr == {32'h1, 16'h0306}, "R9 new page used", last_rd_addr,
            {32'h1, 16'h0306});
        end_cycle();
    endtask

    task automatic t_bad_select();
        xfer(1, 16'h0009, 16'h0000, 2'b11, -1, code, rd, oe_b, oe_a, st, quiet);
        chk(code == 2'b10, "R3 page range ERR", code, 2'b10);
        wr0 = wr_cnt;
        xfer(1, 16'h0010, 16'hFFFF, 2'b11, -1, code, rd, oe_b, oe_a, st, quiet);
        chk(code == 2'b00 && wr_cnt == wr0, "R3 dead cycle ignored", {code, 8'(wr_cnt)},
            {2'b00, 8'(wr0)});
        end_cycle();
        mem_ready = 1'b0;
        xfer(1, 16'h0001, 16'h0000, 2'b11, -1, code, rd, oe_b, oe_a, st, quiet);
        chk(code == 2'b11, "R3 not ready gives RTY (R4 code 11)", code, 2'b11);
        mem_ready = 1'b1;
        end_cycle();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_write_cycle();
        t_read_cycle();
        t_stall();
        t_new_cycle();
        t_bad_select();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule